// File: doc/BRIEF.md
# Module Clock Gating Controller

This block decides, cycle by cycle, whether one functional module receives its clock. The module can be in one of five power states: running, idle, draining toward sleep, asleep, or switched off by software. Three sources can stop the clock, and they are ranked. A static off bit from a control register wins over everything else. A chip-wide sleep request comes next, but only when the module's respond bit is set. Idle gating comes last. It follows either the module's own "no work" indication or a software idle request, depending on a select bit.

A sleep request does not stop the clock immediately. The controller first enters a draining state and keeps the clock running while the module reports outstanding operations. The clock stops on the first edge at which the busy input is low. When the sleep request is withdrawn, the module returns to running and its clock comes back.

The enable goes through a latch that is open only while the clock is low, and the gated clock is the AND of the clock and that latch. Changes to the enable can therefore never shorten or split a clock pulse. Three status bits report the sleep, idle and off states.

Top module: `modclk_gate_ctrl`

## Requirements
- R1: After reset the state is running: `clk_en` is 1 and `st_sleep`, `st_idle` and `st_off` are all 0. In running, `clk_en` stays 1.
- R2: With `cfg_off` = 1 at a clock edge, the state after that edge is off: `st_off` = 1 and `clk_en` = 0. This holds whatever the sleep, idle and busy inputs are.
- R3: With `cfg_sleep_respond` = 0, `sleep_req` has no effect. The state follows only the off and idle rules, and `st_sleep` stays 0.
- R4: With `cfg_sleep_respond` = 1 and `sleep_req` = 1, a running or idle module enters draining at the next edge. Draining keeps `clk_en` = 1, and all three status bits are 0 while `busy` is 1.
- R5: Draining becomes asleep at the first edge at which `busy` = 0. Asleep gives `st_sleep` = 1 and `clk_en` = 0.
- R6: If the sleep request stops being honoured (`sleep_req` = 0) while the module is asleep or draining, the state after the next edge is running with `clk_en` = 1, even if an idle condition is present.
- R7: With `cfg_idle_sw` = 0, `hw_no_work` = 1 at an edge in running gives idle after that edge (`st_idle` = 1, `clk_en` = 0). `hw_no_work` = 0 gives running again after the next edge.
- R8: With `cfg_idle_sw` = 1, the idle source is `sw_idle_req` and `hw_no_work` is ignored.
- R9: `sleep_req` seen while off has no effect: the state stays off. If `cfg_off` is cleared while a sleep request is still honoured, the next state is draining, not running.
- R10: `gclk` is 0 whenever `clk` is 0. During each high phase of `clk`, `gclk` equals the `clk_en` value that held through the preceding low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_off | input | 1 | Static off bit from the control register |
| cfg_sleep_respond | input | 1 | 1 = honour the global sleep request |
| cfg_idle_sw | input | 1 | Idle source select: 1 = software request, 0 = module indication |
| sleep_req | input | 1 | Chip-wide sleep request |
| hw_no_work | input | 1 | Module reports it has nothing to do |
| sw_idle_req | input | 1 | Software idle request |
| busy | input | 1 | Module still has pending operations |
| clk_en | output | 1 | Clock enable decoded from the state register |
| gclk | output | 1 | Glitch-free gated clock to the module |
| st_sleep | output | 1 | Status: asleep |
| st_idle | output | 1 | Status: idle |
| st_off | output | 1 | Status: statically off |

## Verification
Every input sampled at a rising edge has its effect on `clk_en` and the status bits right after that edge, one register stage later. The bench changes its inputs just after each falling edge and checks the registered outputs one time step after the next falling edge. This is half a cycle after the edge that updated them. The gated clock lags by another half cycle: each high phase carries the enable that was set before the edge that opened it. The bench therefore checks `gclk` shortly after each rising edge against the model's enable from before that edge, and checks that `gclk` is 0 in every low phase.

// File: rtl/cgc_pkg.sv
package cgc_pkg;

  localparam int PSTATE_W = 3;

  typedef enum logic [PSTATE_W-1:0] {
    PS_RUN   = 3'd0,
    PS_IDLE  = 3'd1,
    PS_DRAIN = 3'd2,
    PS_SLEEP = 3'd3,
    PS_OFF   = 3'd4
  } pstate_t;

  // idle wanted from the selected source
  function automatic logic idle_wanted(input logic use_sw, input logic sw_req,
                                       input logic hw_idle);
    return use_sw ? sw_req : hw_idle;
  endfunction

  // clock runs in RUN and while draining
  function automatic logic clock_on(input pstate_t s);
    return (s == PS_RUN) || (s == PS_DRAIN);
  endfunction

endpackage

// File: rtl/cgc_next.sv
module cgc_next
  import cgc_pkg::*;
(
  input  pstate_t cur,
  input  logic    off_i,
  input  logic    respond_i,
  input  logic    sleep_i,
  input  logic    busy_i,
  input  logic    idle_i,
  output pstate_t nxt,
  output logic    sleep_eff,
  output logic    drain_done
);

  assign sleep_eff  = respond_i & sleep_i;
  assign drain_done = (cur == PS_DRAIN) & sleep_eff & ~busy_i & ~off_i;

  always_comb begin
    nxt = PS_RUN;
    if (off_i) begin
      nxt = PS_OFF;
    end else if (sleep_eff) begin
      unique case (cur)
        PS_SLEEP: nxt = PS_SLEEP;
        PS_DRAIN: nxt = busy_i ? PS_DRAIN : PS_SLEEP;
        default:  nxt = PS_DRAIN;
      endcase
    end else begin
      unique case (cur)
        PS_SLEEP, PS_DRAIN: nxt = PS_RUN;
        default:            nxt = idle_i ? PS_IDLE : PS_RUN;
      endcase
    end
  end

endmodule

// File: rtl/cgc_status.sv
module cgc_status
  import cgc_pkg::*;
(
  input  pstate_t st,
  output logic    en_o,
  output logic    sleep_o,
  output logic    idle_o,
  output logic    off_o,
  output logic    drain_o
);

  assign en_o    = clock_on(st);
  assign sleep_o = (st == PS_SLEEP);
  assign idle_o  = (st == PS_IDLE);
  assign off_o   = (st == PS_OFF);
  assign drain_o = (st == PS_DRAIN);

endmodule

// File: rtl/cgc_clkgate.sv
module cgc_clkgate (
  input  logic clk_i,
  input  logic en_i,
  output logic en_latched,
  output logic gclk_o
);

  // latch open during the low phase only
  always_latch begin
    if (!clk_i) en_latched = en_i;
  end

  assign gclk_o = clk_i & en_latched;

endmodule

// File: rtl/modclk_gate_ctrl.sv
module modclk_gate_ctrl
  import cgc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_off,
  input  logic cfg_sleep_respond,
  input  logic cfg_idle_sw,
  input  logic sleep_req,
  input  logic hw_no_work,
  input  logic sw_idle_req,
  input  logic busy,
  output logic clk_en,
  output logic gclk,
  output logic st_sleep,
  output logic st_idle,
  output logic st_off
);

  pstate_t state_q;
  pstate_t state_d;
  logic    idle_want;
  logic    sleep_eff;
  logic    drain_done;
  logic    in_drain;
  logic    lat_en;

  assign idle_want = idle_wanted(cfg_idle_sw, sw_idle_req, hw_no_work);

  cgc_next u_next (
    .cur        (state_q),
    .off_i      (cfg_off),
    .respond_i  (cfg_sleep_respond),
    .sleep_i    (sleep_req),
    .busy_i     (busy),
    .idle_i     (idle_want),
    .nxt        (state_d),
    .sleep_eff  (sleep_eff),
    .drain_done (drain_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PS_RUN;
    else        state_q <= state_d;
  end

  cgc_status u_stat (
    .st      (state_q),
    .en_o    (clk_en),
    .sleep_o (st_sleep),
    .idle_o  (st_idle),
    .off_o   (st_off),
    .drain_o (in_drain)
  );

  cgc_clkgate u_cg (
    .clk_i      (clk),
    .en_i       (clk_en),
    .en_latched (lat_en),
    .gclk_o     (gclk)
  );

endmodule

// File: rtl/cgc_checker.sv
module cgc_checker (
  input logic clk,
  input logic rst_n,
  input logic cfg_off,
  input logic cfg_sleep_respond,
  input logic sleep_req,
  input logic busy,
  input logic clk_en,
  input logic lat_en,
  input logic st_sleep,
  input logic st_idle,
  input logic st_off,
  input logic in_drain,
  input logic sleep_eff,
  input logic drain_done
);

  a_r2_off_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_off |=> (st_off && !clk_en));

  a_r3_no_sleep_when_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_sleep_respond && !st_sleep) |=> !st_sleep);

  a_r4_clock_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (in_drain && busy && sleep_eff && !cfg_off) |=> (clk_en && in_drain));

  a_r5_sleep_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
    drain_done |=> (st_sleep && !clk_en));

  a_r5_no_sleep_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (in_drain && busy) |=> !st_sleep);

  a_r6_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (st_sleep && !sleep_req && !cfg_off) |=> (clk_en && !st_sleep));

  a_r9_off_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (st_off && cfg_off) |=> st_off);

  a_r10_latch_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    lat_en == clk_en);

  a_r1_status_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({st_sleep, st_idle, st_off, in_drain}));

endmodule

bind modclk_gate_ctrl cgc_checker u_chk (
  .clk               (clk),
  .rst_n             (rst_n),
  .cfg_off           (cfg_off),
  .cfg_sleep_respond (cfg_sleep_respond),
  .sleep_req         (sleep_req),
  .busy              (busy),
  .clk_en            (clk_en),
  .lat_en            (lat_en),
  .st_sleep          (st_sleep),
  .st_idle           (st_idle),
  .st_off            (st_off),
  .in_drain          (in_drain),
  .sleep_eff         (sleep_eff),
  .drain_done        (drain_done)
);

// File: tb/sim_modclk_gate_ctrl.sv
module sim_modclk_gate_ctrl;

  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_off = 1'b0, cfg_sleep_respond = 1'b0, cfg_idle_sw = 1'b0;
  logic sleep_req = 1'b0, hw_no_work = 1'b0, sw_idle_req = 1'b0, busy = 1'b0;
  logic clk_en, gclk, st_sleep, st_idle, st_off;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  // model states: 0 run, 1 idle, 2 drain, 3 sleep, 4 off
  int mstate = 0;

  always #(PERIOD/2) clk = ~clk;

  modclk_gate_ctrl u0 (
    .clk (clk), .rst_n (rst_n), .cfg_off (cfg_off),
    .cfg_sleep_respond (cfg_sleep_respond), .cfg_idle_sw (cfg_idle_sw),
    .sleep_req (sleep_req), .hw_no_work (hw_no_work), .sw_idle_req (sw_idle_req),
    .busy (busy), .clk_en (clk_en), .gclk (gclk), .st_sleep (st_sleep),
    .st_idle (st_idle), .st_off (st_off)
  );

  function automatic int model_next(int s);
    bit honour;
    bit want_idle;
    honour = cfg_sleep_respond && sleep_req;
    want_idle = cfg_idle_sw ? sw_idle_req : hw_no_work;
    if (cfg_off) return 4;
    if (honour && s == 3) return 3;
    if (honour && s == 2) return busy ? 2 : 3;
    if (honour) return 2;
    if (s == 2 || s == 3) return 0;
    return want_idle ? 1 : 0;
  endfunction

  function automatic bit model_en(int s);
    return (s == 0) || (s == 2);
  endfunction

  task automatic chk(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_outs(string tag);
    chk(tag, "clk_en",   clk_en,   model_en(mstate));
    chk(tag, "st_sleep", st_sleep, mstate == 3);
    chk(tag, "st_idle",  st_idle,  mstate == 1);
    chk(tag, "st_off",   st_off,   mstate == 4);
  endtask

  // one cycle: inputs already driven; ends at falling edge + 1
  task automatic step(string tag);
    bit prev_en;
    prev_en = model_en(mstate);
    @(posedge clk);
    mstate = model_next(mstate);
    #2;
    chk("R10", "gclk high phase", gclk, prev_en);
    @(negedge clk);
    #1;
    chk("R10", "gclk low phase", gclk, 1'b0);
    check_outs(tag);
  endtask

  task automatic drive(bit off, bit resp, bit isw, bit slp, bit hw, bit sw, bit bsy);
    cfg_off = off; cfg_sleep_respond = resp; cfg_idle_sw = isw;
    sleep_req = slp; hw_no_work = hw; sw_idle_req = sw; busy = bsy;
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    mstate = 0;
    check_outs("R1");
    rst_n = 1'b1;
    repeat (3) step("R1");

    // R7 idle from module indication
    drive(0, 0, 0, 0, 1, 0, 0);
    repeat (3) step("R7");
    drive(0, 0, 0, 0, 0, 0, 0);
    step("R7");

    // R8 software idle source
    drive(0, 0, 1, 0, 0, 1, 0);
    repeat (2) step("R8");
    drive(0, 0, 1, 0, 1, 0, 0);
    repeat (2) step("R8");

    // R3 sleep ignored
    drive(0, 0, 0, 1, 0, 0, 1);
    repeat (3) step("R3");
    drive(0, 0, 0, 1, 1, 0, 0);
    repeat (2) step("R3");

    // R4/R5/R6 sleep handshake with drain
    drive(0, 1, 0, 1, 0, 0, 1);
    repeat (4) step("R4");
    drive(0, 1, 0, 1, 0, 0, 0);
    repeat (2) step("R5");
    drive(0, 1, 0, 0, 1, 0, 0);
    step("R6");
    drive(0, 1, 0, 0, 0, 0, 0);
    step("R6");

    // R6 withdraw during drain
    drive(0, 1, 0, 1, 0, 0, 1);
    repeat (2) step("R4");
    drive(0, 1, 0, 0, 0, 0, 1);
    step("R6");

    // R4 sleep from idle
    drive(0, 1, 0, 0, 1, 0, 0);
    step("R7");
    drive(0, 1, 0, 1, 1, 0, 1);
    repeat (2) step("R4");
    drive(0, 1, 0, 1, 1, 0, 0);
    step("R5");

    // R2/R9 off wins, sleep while off ignored
    drive(1, 1, 0, 1, 0, 0, 1);
    repeat (3) step("R2");
    drive(1, 1, 0, 1, 1, 1, 0);
    repeat (2) step("R9");
    drive(0, 1, 0, 1, 0, 0, 1);
    repeat (2) step("R9");
    drive(0, 1, 0, 1, 0, 0, 0);
    step("R5");
    drive(1, 1, 0, 0, 0, 0, 0);
    step("R2");
    drive(0, 1, 0, 0, 1, 0, 0);
    step("R7");

    // mixed pattern sweep
    begin
      logic [15:0] lf;
      lf = 16'hACE1;
      for (int i = 0; i < 400; i++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        drive(lf[4:0] == 5'd0, lf[5] | lf[6], lf[7] & lf[9], lf[8] & lf[10],
              lf[11], lf[12], lf[13] & lf[14]);
        case (model_next(mstate))
          4: step("R2");
          3: step("R5");
          2: step("R4");
          1: step("R7");
          default: step("R1");
        endcase
      end
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule